// File: doc/BRIEF.md
# Windowed Address Decoder with Default Target

The decoder turns a transaction address into a target identifier. A set of programmable windows each cover an inclusive range of 1 MiB blocks. A window that is enabled and covers the address supplies its own target identifier. An address that no enabled window covers goes to a default target, which a global register holds. Each window can also limit writes, reads or both to secure requesters. A non-secure access that is refused is reported as a security violation and not as a hit.

All state is set up through a 32-bit word-addressed register port with one-cycle registered read data. The lookup port samples an address, a secure qualifier and a write qualifier on every clock. It returns the target, a hit flag and a violation flag one clock later. The comparison uses only the address bits above the 1 MiB boundary. When windows overlap, the lowest-numbered window decides the result.

Top module: `addr_window_decoder`

## Requirements
- R1: After reset every window is disabled and the default target is 0. Every lookup reports hit=0, violation=0 and target 0.
- R2: Register word index 4*w+0 is the control of window w, 4*w+1 its security, 4*w+2 its low bound and 4*w+3 its high bound. Index 4*NUM_WIN is the global register. Read data appears one clock after the index. Other indices read 0, and writes to them are ignored.
- R3: In a control word, bit 0 is the enable and bits [11:4] are the target identifier. All other bits read back as 0.
- R4: Bits [31:4] of the low and high bound words hold address bits [47:20], and bits [3:0] read as 0. A window covers an address when low <= addr[47:20] <= high, so both bounds are included.
- R5: A disabled window never matches, whatever its bounds are.
- R6: An address that no enabled window matches gives hit=0 and violation=0. Its target is the value in bits [11:4] of the global register.
- R7: When several enabled windows match, the lowest-numbered one supplies the result.
- R8: In a security word, bit 0 restricts writes to secure requesters and bit 1 restricts reads. A refused non-secure access to the selected window gives violation=1, hit=0 and the default target. Secure accesses are never refused.
- R9: Lookup results are registered. They reflect the inputs present at the previous rising clock edge.
- R10: hit and violation are never 1 together. Rewriting the target field of an enabled window changes the returned target while the window stays enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | RA_W | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the index of the previous cycle |
| lk_addr | input | ADDR_W | Lookup address |
| lk_secure | input | 1 | Requester is secure |
| lk_write | input | 1 | Access is a write (0 = read) |
| lk_hit | output | 1 | An enabled window matched and allowed the access |
| lk_viol | output | 1 | The selected window refused a non-secure access |
| lk_target | output | TID_W | Resulting target identifier |

## Verification
The checker watches invariants on every cycle:
- hit and violation are exclusive.
- A violation is only raised for a non-secure request.
- A miss returns the default target of the previous cycle.
- With all windows disabled there is never a hit.
- Bound words read back with a zero low nibble.
- Outputs are clear right after reset.

Only the bench scenarios can show the other behaviours: which window wins an overlap, that both bounds are inclusive, that each qualifier maps onto the right restriction bit, that stray control bits are dropped, and that a target rewrite takes effect.

// File: rtl/awd_pkg.sv
package awd_pkg;
  localparam int REG_W   = 32;
  localparam int FLD_LSB = 4;
  localparam int MIB_SH  = 20;

  typedef enum logic [1:0] {
    SLOT_CTRL = 2'd0,
    SLOT_SEC  = 2'd1,
    SLOT_LOW  = 2'd2,
    SLOT_HIGH = 2'd3
  } slot_e;
endpackage

// File: rtl/awd_regfile.sv
module awd_regfile
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int TID_W   = 8,
  parameter int BND_W   = 28,
  parameter int RA_W    = 6
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              reg_wr,
  input  logic [RA_W-1:0]                   reg_addr,
  input  logic [REG_W-1:0]                  reg_wdata,
  output logic [REG_W-1:0]                  reg_rdata,
  output logic [NUM_WIN-1:0]                win_en,
  output logic [NUM_WIN-1:0][TID_W-1:0]     win_tid,
  output logic [NUM_WIN-1:0]                win_ws,
  output logic [NUM_WIN-1:0]                win_rs,
  output logic [NUM_WIN-1:0][BND_W-1:0]     win_lo,
  output logic [NUM_WIN-1:0][BND_W-1:0]     win_hi,
  output logic [TID_W-1:0]                  dflt_tid
);
  localparam int WI_W    = $clog2(NUM_WIN);
  localparam int GLB_IDX = NUM_WIN * 4;

  logic            in_win;
  logic            is_glb;
  logic [WI_W-1:0] wsel;
  slot_e           slot;
  logic [REG_W-1:0] rd_nxt;
  logic            unused_wd;

  assign in_win    = reg_addr < RA_W'(GLB_IDX);
  assign is_glb    = reg_addr == RA_W'(GLB_IDX);
  assign wsel      = reg_addr[2 +: WI_W];
  assign slot      = slot_e'(reg_addr[1:0]);
  assign unused_wd = ^reg_wdata[3:2];

  always_ff @(posedge clk) begin
    if (rst) begin
      win_en   <= '0;
      win_tid  <= '0;
      win_ws   <= '0;
      win_rs   <= '0;
      win_lo   <= '0;
      win_hi   <= '0;
      dflt_tid <= '0;
    end else if (reg_wr) begin
      if (is_glb) dflt_tid <= reg_wdata[FLD_LSB +: TID_W];
      for (int i = 0; i < NUM_WIN; i++) begin
        if (in_win && (int'(wsel) == i)) begin
          case (slot)
            SLOT_CTRL: begin
              win_en[i]  <= reg_wdata[0];
              win_tid[i] <= reg_wdata[FLD_LSB +: TID_W];
            end
            SLOT_SEC: begin
              win_ws[i] <= reg_wdata[0];
              win_rs[i] <= reg_wdata[1];
            end
            SLOT_LOW:  win_lo[i] <= reg_wdata[FLD_LSB +: BND_W];
            SLOT_HIGH: win_hi[i] <= reg_wdata[FLD_LSB +: BND_W];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_nxt = '0;
    if (in_win) begin
      case (slot)
        SLOT_CTRL: begin
          rd_nxt[0]               = win_en[wsel];
          rd_nxt[FLD_LSB +: TID_W] = win_tid[wsel];
        end
        SLOT_SEC: begin
          rd_nxt[0] = win_ws[wsel];
          rd_nxt[1] = win_rs[wsel];
        end
        SLOT_LOW:  rd_nxt[FLD_LSB +: BND_W] = win_lo[wsel];
        SLOT_HIGH: rd_nxt[FLD_LSB +: BND_W] = win_hi[wsel];
        default: ;
      endcase
    end else if (is_glb) begin
      rd_nxt[FLD_LSB +: TID_W] = dflt_tid;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_nxt;
  end
endmodule

// File: rtl/awd_win_match.sv
module awd_win_match #(
  parameter int BND_W = 28
) (
  input  logic             en_i,
  input  logic [BND_W-1:0] lo_i,
  input  logic [BND_W-1:0] hi_i,
  input  logic [BND_W-1:0] key_i,
  output logic             match_o
);
  assign match_o = en_i && (key_i >= lo_i) && (key_i <= hi_i);
endmodule

// File: rtl/awd_prio.sv
module awd_prio #(
  parameter int NUM_WIN = 8,
  parameter int WI_W    = 3
) (
  input  logic [NUM_WIN-1:0] match_i,
  output logic               any_o,
  output logic [WI_W-1:0]    idx_o
);
  always_comb begin
    any_o = |match_i;
    idx_o = '0;
    for (int i = NUM_WIN - 1; i >= 0; i--) begin
      if (match_i[i]) idx_o = WI_W'(i);
    end
  end
endmodule

// File: rtl/addr_window_decoder.sv
module addr_window_decoder
  import awd_pkg::*;
#(
  parameter int NUM_WIN = 8,
  parameter int ADDR_W  = 48,
  parameter int TID_W   = 8,
  localparam int RA_W   = $clog2(NUM_WIN * 4 + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [ADDR_W-1:0] lk_addr,
  input  logic              lk_secure,
  input  logic              lk_write,
  output logic              lk_hit,
  output logic              lk_viol,
  output logic [TID_W-1:0]  lk_target
);
  localparam int BND_W = ADDR_W - MIB_SH;
  localparam int WI_W  = $clog2(NUM_WIN);

  logic [NUM_WIN-1:0]            win_en;
  logic [NUM_WIN-1:0][TID_W-1:0] win_tid;
  logic [NUM_WIN-1:0]            win_ws;
  logic [NUM_WIN-1:0]            win_rs;
  logic [NUM_WIN-1:0][BND_W-1:0] win_lo;
  logic [NUM_WIN-1:0][BND_W-1:0] win_hi;
  logic [TID_W-1:0]              dflt_tid;
  logic [NUM_WIN-1:0]            match;
  logic [BND_W-1:0]              key;
  logic                          any;
  logic [WI_W-1:0]               sel;
  logic                          blocked;
  logic                          unused_low;

  assign key        = lk_addr[ADDR_W-1:MIB_SH];
  assign unused_low = ^lk_addr[MIB_SH-1:0];

  awd_regfile #(
    .NUM_WIN(NUM_WIN), .TID_W(TID_W), .BND_W(BND_W), .RA_W(RA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .win_en(win_en),
    .win_tid(win_tid), .win_ws(win_ws), .win_rs(win_rs),
    .win_lo(win_lo), .win_hi(win_hi), .dflt_tid(dflt_tid)
  );

  for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
    awd_win_match #(.BND_W(BND_W)) u_match (
      .en_i(win_en[g]), .lo_i(win_lo[g]), .hi_i(win_hi[g]),
      .key_i(key), .match_o(match[g])
    );
  end

  awd_prio #(.NUM_WIN(NUM_WIN), .WI_W(WI_W)) u_prio (
    .match_i(match), .any_o(any), .idx_o(sel)
  );

  assign blocked = !lk_secure && (lk_write ? win_ws[sel] : win_rs[sel]);

  always_ff @(posedge clk) begin
    if (rst) begin
      lk_hit    <= 1'b0;
      lk_viol   <= 1'b0;
      lk_target <= '0;
    end else begin
      lk_hit    <= any && !blocked;
      lk_viol   <= any && blocked;
      lk_target <= (any && !blocked) ? win_tid[sel] : dflt_tid;
    end
  end
endmodule

// File: rtl/awd_checker.sv
module awd_checker #(
  parameter int NUM_WIN = 8,
  parameter int TID_W   = 8,
  parameter int RA_W    = 6
) (
  input logic               clk,
  input logic               rst,
  input logic [RA_W-1:0]    reg_addr,
  input logic [31:0]        reg_rdata,
  input logic               lk_secure,
  input logic               lk_hit,
  input logic               lk_viol,
  input logic [TID_W-1:0]   lk_target,
  input logic [TID_W-1:0]   dflt_tid,
  input logic [NUM_WIN-1:0] win_en
);
  p_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(lk_hit && lk_viol));

  p_viol_nonsec_r8: assert property (@(posedge clk) disable iff (rst)
    lk_viol |-> !$past(lk_secure));

  p_miss_default_r6: assert property (@(posedge clk) disable iff (rst)
    (!lk_hit && !lk_viol) |-> (lk_target == $past(dflt_tid)));

  p_disabled_nohit_r5: assert property (@(posedge clk) disable iff (rst)
    ($past(win_en) == '0) |-> !lk_hit);

  p_bound_nibble_r4: assert property (@(posedge clk) disable iff (rst)
    (($past(reg_addr) < RA_W'(NUM_WIN * 4)) && $past(reg_addr[1]))
      |-> (reg_rdata[3:0] == 4'h0));

  p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!lk_hit && !lk_viol && lk_target == '0));
endmodule

bind addr_window_decoder awd_checker #(
  .NUM_WIN(NUM_WIN), .TID_W(TID_W), .RA_W(RA_W)
) u_chk (
  .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
  .lk_secure(lk_secure), .lk_hit(lk_hit), .lk_viol(lk_viol),
  .lk_target(lk_target), .dflt_tid(dflt_tid), .win_en(win_en)
);

// File: tb/addr_window_decoder_bench.sv
module addr_window_decoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 14;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [5:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [47:0] lk_addr = '0;
  logic        lk_secure = 1'b0;
  logic        lk_write = 1'b0;
  logic        lk_hit;
  logic        lk_viol;
  logic [7:0]  lk_target;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  // {addr, secure, write, exp_hit, exp_viol, exp_target}
  localparam logic [59:0] VEC [NV] = '{
    {48'h0000_1000_0000, 1'b1, 1'b1, 1'b1, 1'b0, 8'h11},
    {48'h0000_1FFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0, 8'h11},
    {48'h0000_1C00_0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h11},
    {48'h0000_2000_0000, 1'b1, 1'b0, 1'b1, 1'b0, 8'h22},
    {48'h0000_0FFF_FFFF, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A},
    {48'h0000_1500_0000, 1'b0, 1'b1, 1'b0, 1'b1, 8'h5A},
    {48'h0000_1500_0000, 1'b0, 1'b0, 1'b1, 1'b0, 8'h11},
    {48'h0000_2500_0000, 1'b0, 1'b0, 1'b0, 1'b1, 8'h5A},
    {48'h0000_2500_0000, 1'b0, 1'b1, 1'b1, 1'b0, 8'h22},
    {48'h0000_4001_2345, 1'b0, 1'b0, 1'b1, 1'b0, 8'h44},
    {48'h0000_4010_0000, 1'b0, 1'b0, 1'b0, 1'b0, 8'h5A},
    {48'h0000_3000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A},
    {48'h0000_8000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A},
    {48'h8000_1000_0000, 1'b1, 1'b0, 1'b0, 1'b0, 8'h5A}
  };
  localparam string TAG [NV] = '{
    "R4", "R4", "R7", "R7", "R6", "R8", "R8", "R8", "R8",
    "R4", "R4", "R4", "R5", "R4"
  };

  addr_window_decoder u_addr_window_decoder (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .lk_addr(lk_addr),
    .lk_secure(lk_secure), .lk_write(lk_write), .lk_hit(lk_hit),
    .lk_viol(lk_viol), .lk_target(lk_target)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
    @(negedge clk);
    reg_addr = a;
    @(negedge clk);
    chk(req, {16'h0, reg_rdata}, {16'h0, exp});
  endtask

  task automatic look(input logic [47:0] a, input logic s, input logic w);
    @(negedge clk);
    lk_addr = a; lk_secure = s; lk_write = w;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    look(48'h0000_1000_0000, 1'b0, 1'b1);
    chk("R1", {37'h0, lk_hit, lk_viol, lk_target}, 48'h0);
    rd_chk("R1", 6'd32, 32'h0);
    rd_chk("R1", 6'd0, 32'h0);

    // configuration
    wr(6'd0, 32'h0000_0111); wr(6'd1, 32'h0000_0001);
    wr(6'd2, 32'h0000_100F); wr(6'd3, 32'h0000_1FF0);
    wr(6'd4, 32'h0000_0221); wr(6'd5, 32'h0000_0002);
    wr(6'd6, 32'h0000_1800); wr(6'd7, 32'h0000_2FF0);
    wr(6'd8, 32'h0000_0330);
    wr(6'd10, 32'h0000_0000); wr(6'd11, 32'h0000_FFF0);
    wr(6'd12, 32'hFFFF_0441);
    wr(6'd14, 32'h0000_4000); wr(6'd15, 32'h0000_4000);
    wr(6'd32, 32'h0000_05A0);
    wr(6'd40, 32'hFFFF_FFFF);

    // register readback
    rd_chk("R4", 6'd2, 32'h0000_1000);
    rd_chk("R3", 6'd12, 32'h0000_0441);
    rd_chk("R8", 6'd5, 32'h0000_0002);
    rd_chk("R2", 6'd40, 32'h0);
    rd_chk("R2", 6'd32, 32'h0000_05A0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      look(VEC[i][59:12], VEC[i][11], VEC[i][10]);
      chk(TAG[i], {38'h0, lk_hit, lk_viol, lk_target}, {38'h0, VEC[i][9:0]});
    end

    // R9: output holds until the next edge
    look(48'h0000_4000_0000, 1'b1, 1'b0);
    lk_addr = 48'h0000_7000_0000;
    #1;
    chk("R9", {39'h0, lk_hit, lk_target}, {39'h0, 1'b1, 8'h44});
    @(negedge clk);
    chk("R9", {39'h0, lk_hit, lk_target}, {39'h0, 1'b0, 8'h5A});

    // R10: retarget an enabled window
    wr(6'd12, 32'h0000_0771);
    look(48'h0000_4000_0000, 1'b1, 1'b0);
    chk("R10", {39'h0, lk_hit, lk_target}, {39'h0, 1'b1, 8'h77});

    // R5: disabling a window removes its match
    wr(6'd12, 32'h0000_0770);
    look(48'h0000_4000_0000, 1'b1, 1'b0);
    chk("R5", {39'h0, lk_hit, lk_target}, {39'h0, 1'b0, 8'h5A});

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule